// File: doc/BRIEF.md
# Age-Ordered Issue Queue with Wakeup

This block is the scheduler that sits between an in-order rename stage and the execution ports of an out-of-order core. Every micro-op that needs an execution unit is written into one of its entries, with two source tags, a destination tag and a class. The class says whether the op needs a general ALU or the address-generation port. Loads and the address half of a split store use the address port only to compute their address. The data half of a store and all plain arithmetic use the ALU port. Each source carries a ready bit. The bit is set either at allocation, when rename already found the value in the register file, or later, when the producer's tag is broadcast.

Two broadcast paths wake waiting sources. The first is a completion bus for results with fixed latency, and it takes effect at the next clock edge. The second is a load completion path, used when a load leaves the load-store pipe after one or more passes. It is registered once inside the block, so its tag takes effect one cycle later than the completion bus. Among entries whose sources are both ready, each port takes the oldest of its class when the port is free. Age comes from a sequence number that is stamped at allocation and compared relative to the next number to be handed out. A flush names a sequence number and removes every entry younger than it in the same cycle.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue holds no entry, no port issues, `alloc_full` is low and `alloc_seq` is 0.
- R2: An entry is eligible only while both of its source ready bits are set. Class 0 (ALU, including store data) issues only on the ALU port. Class 1 (load address, store address) issues only on the address port.
- R3: In each cycle, each port presents the eligible entry of its class with the oldest sequence number. An entry that is presented while its port is free is removed at the next clock edge.
- R4: While a port's free input is low, that port presents nothing, and its entries stay queued with their order unchanged.
- R5: A tag on the completion bus at a clock edge sets every matching source ready, so the entry can issue in the next cycle. This includes a source that is allocated in that same cycle.
- R6: A tag on the load completion path sets matching sources ready one edge later than the completion bus would, so the entry can issue two cycles after the broadcast.
- R7: With `flush_valid` high, every entry with a sequence number younger than `flush_seq` is removed at that edge and is not presented in that cycle. The entry carrying `flush_seq` and older entries stay. An allocation in that cycle is dropped.
- R8: `alloc_full` is high when all 16 entries are valid, or when a live entry is 2^SEQ_W-1 allocations old. While it is high, `alloc_valid` is ignored.
- R9: `alloc_seq` shows the sequence number the next accepted micro-op receives. It advances by one, modulo 2^SEQ_W, for each accepted allocation, and age ordering stays correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Rename presents a micro-op |
| alloc_cls | input | 1 | 0 = ALU port, 1 = address port |
| alloc_src1 | input | TAG_W | First source tag |
| alloc_src1_rdy | input | 1 | First source already available |
| alloc_src2 | input | TAG_W | Second source tag |
| alloc_src2_rdy | input | 1 | Second source already available |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_full | output | 1 | Allocation stalled |
| alloc_seq | output | SEQ_W | Sequence number for the next accepted micro-op |
| flush_valid | input | 1 | Remove younger entries |
| flush_seq | input | SEQ_W | Youngest sequence number kept |
| cmp_valid | input | 1 | Completion bus broadcast |
| cmp_tag | input | TAG_W | Completion bus tag |
| ld_cmp_valid | input | 1 | Load completion broadcast |
| ld_cmp_tag | input | TAG_W | Load completion tag |
| alu_free | input | 1 | ALU port can accept an op |
| alu_iss_valid | output | 1 | ALU port issue |
| alu_iss_src1 | output | TAG_W | Issued first source tag |
| alu_iss_src2 | output | TAG_W | Issued second source tag |
| alu_iss_dst | output | TAG_W | Issued destination tag |
| alu_iss_seq | output | SEQ_W | Issued sequence number |
| agu_free | input | 1 | Address port can accept an op |
| agu_iss_valid | output | 1 | Address port issue |
| agu_iss_src1 | output | TAG_W | Issued first source tag |
| agu_iss_src2 | output | TAG_W | Issued second source tag |
| agu_iss_dst | output | TAG_W | Issued destination tag |
| agu_iss_seq | output | SEQ_W | Issued sequence number |

## Verification
The assertions check four properties on every cycle. The sequence counter advances only on an accepted allocation. A full queue stays full until something leaves. An issued entry is never presented twice. A flush never lets a younger entry out in its own cycle. Other behaviour can only be shown by the bench's scenarios against its reference model: oldest-first choice across the sequence wrap, the extra cycle on the load wakeup path, wakeup of a source allocated in the same cycle, and the stall once the age window is exhausted.

// File: rtl/age_issue_queue.sv
module age_issue_queue #(
  parameter int DEPTH = 16,
  parameter int TAG_W = 6,
  parameter int SEQ_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic             alloc_cls,
  input  logic [TAG_W-1:0] alloc_src1,
  input  logic             alloc_src1_rdy,
  input  logic [TAG_W-1:0] alloc_src2,
  input  logic             alloc_src2_rdy,
  input  logic [TAG_W-1:0] alloc_dst,
  output logic             alloc_full,
  output logic [SEQ_W-1:0] alloc_seq,
  input  logic             flush_valid,
  input  logic [SEQ_W-1:0] flush_seq,
  input  logic             cmp_valid,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic             ld_cmp_valid,
  input  logic [TAG_W-1:0] ld_cmp_tag,
  input  logic             alu_free,
  output logic             alu_iss_valid,
  output logic [TAG_W-1:0] alu_iss_src1,
  output logic [TAG_W-1:0] alu_iss_src2,
  output logic [TAG_W-1:0] alu_iss_dst,
  output logic [SEQ_W-1:0] alu_iss_seq,
  input  logic             agu_free,
  output logic             agu_iss_valid,
  output logic [TAG_W-1:0] agu_iss_src1,
  output logic [TAG_W-1:0] agu_iss_src2,
  output logic [TAG_W-1:0] agu_iss_dst,
  output logic [SEQ_W-1:0] agu_iss_seq
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [SEQ_W-1:0] MAX_AGE = '1;

  logic [DEPTH-1:0] vld, cls, rdy1, rdy2;
  logic [TAG_W-1:0] src1 [DEPTH];
  logic [TAG_W-1:0] src2 [DEPTH];
  logic [TAG_W-1:0] dst  [DEPTH];
  logic [SEQ_W-1:0] seq  [DEPTH];
  logic [SEQ_W-1:0] age  [DEPTH];
  logic [SEQ_W-1:0] nxt;
  logic             ldq_v;
  logic [TAG_W-1:0] ldq_t;

  logic [DEPTH-1:0] kill, elig, aged_out;
  logic [SEQ_W-1:0] flush_age;
  logic             sel_v [2];
  logic [IDX_W-1:0] sel_i [2];
  logic [SEQ_W-1:0] sel_a [2];
  logic [1:0]       port_free, port_go;
  logic [IDX_W-1:0] free_i;
  logic             accept;

  function automatic logic woken(input logic [TAG_W-1:0] t);
    return (cmp_valid && cmp_tag == t) || (ldq_v && ldq_t == t);
  endfunction

  assign flush_age = nxt - flush_seq;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ent
      assign age[g]      = nxt - seq[g];
      assign kill[g]     = flush_valid && (age[g] < flush_age);
      assign elig[g]     = vld[g] && rdy1[g] && rdy2[g] && !kill[g];
      assign aged_out[g] = vld[g] && (age[g] == MAX_AGE);
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      sel_v[p] = 1'b0;
      sel_i[p] = '0;
      sel_a[p] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (elig[i] && (cls[i] == p[0]) && (!sel_v[p] || age[i] > sel_a[p])) begin
          sel_v[p] = 1'b1;
          sel_i[p] = IDX_W'(i);
          sel_a[p] = age[i];
        end
      end
    end
  end

  always_comb begin
    free_i = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) free_i = IDX_W'(i);
  end

  assign port_free  = {agu_free, alu_free};
  assign port_go[0] = sel_v[0] && port_free[0];
  assign port_go[1] = sel_v[1] && port_free[1];
  assign alloc_full = (&vld) || (|aged_out);
  assign alloc_seq  = nxt;
  assign accept     = alloc_valid && !alloc_full && !flush_valid;

  assign alu_iss_valid = port_go[0];
  assign alu_iss_src1  = src1[sel_i[0]];
  assign alu_iss_src2  = src2[sel_i[0]];
  assign alu_iss_dst   = dst[sel_i[0]];
  assign alu_iss_seq   = seq[sel_i[0]];
  assign agu_iss_valid = port_go[1];
  assign agu_iss_src1  = src1[sel_i[1]];
  assign agu_iss_src2  = src2[sel_i[1]];
  assign agu_iss_dst   = dst[sel_i[1]];
  assign agu_iss_seq   = seq[sel_i[1]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= '0;
      cls   <= '0;
      rdy1  <= '0;
      rdy2  <= '0;
      nxt   <= '0;
      ldq_v <= 1'b0;
      ldq_t <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        src1[i] <= '0;
        src2[i] <= '0;
        dst[i]  <= '0;
        seq[i]  <= '0;
      end
    end else begin
      ldq_v <= ld_cmp_valid;
      ldq_t <= ld_cmp_tag;
      for (int i = 0; i < DEPTH; i++) begin
        if (vld[i]) begin
          if (woken(src1[i])) rdy1[i] <= 1'b1;
          if (woken(src2[i])) rdy2[i] <= 1'b1;
        end
        if (kill[i] ||
            (port_go[0] && sel_i[0] == IDX_W'(i)) ||
            (port_go[1] && sel_i[1] == IDX_W'(i)))
          vld[i] <= 1'b0;
      end
      if (accept) begin
        vld[free_i]  <= 1'b1;
        cls[free_i]  <= alloc_cls;
        src1[free_i] <= alloc_src1;
        src2[free_i] <= alloc_src2;
        dst[free_i]  <= alloc_dst;
        seq[free_i]  <= nxt;
        rdy1[free_i] <= alloc_src1_rdy || woken(alloc_src1);
        rdy2[free_i] <= alloc_src2_rdy || woken(alloc_src2);
        nxt          <= nxt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/age_issue_queue_checker.sv
module age_issue_queue_checker #(
  parameter int SEQ_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_full,
  input logic [SEQ_W-1:0] alloc_seq,
  input logic             flush_valid,
  input logic [SEQ_W-1:0] flush_seq,
  input logic             alu_iss_valid,
  input logic [SEQ_W-1:0] alu_iss_seq,
  input logic             agu_iss_valid,
  input logic [SEQ_W-1:0] agu_iss_seq
);
  logic taken;
  assign taken = alloc_valid && !alloc_full && !flush_valid;

  assert_seq_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> alloc_seq == $past(alloc_seq) + 1'b1);

  assert_seq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> $stable(alloc_seq));

  assert_full_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_full && !alu_iss_valid && !agu_iss_valid && !flush_valid) |=> alloc_full);

  assert_alu_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alu_iss_valid |=> !(alu_iss_valid && alu_iss_seq == $past(alu_iss_seq)));

  assert_agu_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    agu_iss_valid |=> !(agu_iss_valid && agu_iss_seq == $past(agu_iss_seq)));

  assert_alu_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && alu_iss_valid) |->
      SEQ_W'(alloc_seq - alu_iss_seq) >= SEQ_W'(alloc_seq - flush_seq));

  assert_agu_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && agu_iss_valid) |->
      SEQ_W'(alloc_seq - agu_iss_seq) >= SEQ_W'(alloc_seq - flush_seq));
endmodule

bind age_issue_queue age_issue_queue_checker #(.SEQ_W(SEQ_W)) u_checker (.*);

// File: tb/age_issue_queue_bench.sv
module age_issue_queue_bench;
  localparam int TAG_W = 6;
  localparam int SEQ_W = 6;
  localparam int DEPTH = 16;
  localparam int WIN   = (1 << SEQ_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_cls = 0, alloc_src1_rdy = 0, alloc_src2_rdy = 0;
  logic [TAG_W-1:0] alloc_src1 = '0, alloc_src2 = '0, alloc_dst = '0;
  logic alloc_full;
  logic [SEQ_W-1:0] alloc_seq;
  logic flush_valid = 0;
  logic [SEQ_W-1:0] flush_seq = '0;
  logic cmp_valid = 0, ld_cmp_valid = 0;
  logic [TAG_W-1:0] cmp_tag = '0, ld_cmp_tag = '0;
  logic alu_free = 1, agu_free = 1;
  logic alu_iss_valid, agu_iss_valid;
  logic [TAG_W-1:0] alu_iss_src1, alu_iss_src2, alu_iss_dst;
  logic [TAG_W-1:0] agu_iss_src1, agu_iss_src2, agu_iss_dst;
  logic [SEQ_W-1:0] alu_iss_seq, agu_iss_seq;

  always #5 clk = ~clk;

  age_issue_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_age_issue_queue (.*);

  typedef struct {
    int seq; bit cls; int s1; int s2; int dst; bit r1; bit r2;
  } ent_t;

  ent_t q[$];
  int   nxt = 0;
  int   flush_int = 0;
  bit   ldq_v = 0;
  int   ldq_t = 0;
  int   checks = 0, errors = 0;
  bit   done = 0;
  string req = "R1";

  function automatic int pick(bit c, bit fv, int f);
    int b = -1;
    foreach (q[k])
      if (q[k].cls == c && q[k].r1 && q[k].r2 && !(fv && q[k].seq > f))
        if (b < 0 || q[k].seq < q[b].seq) b = k;
    return b;
  endfunction

  function automatic bit model_full();
    int m;
    if (q.size() == DEPTH) return 1'b1;
    if (q.size() == 0) return 1'b0;
    m = q[0].seq;
    foreach (q[k]) if (q[k].seq < m) m = q[k].seq;
    return (nxt - m) >= WIN;
  endfunction

  function automatic bit hit(int t);
    return (cmp_valid && int'(cmp_tag) == t) || (ldq_v && ldq_t == t);
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int a, g;
      a = pick(1'b0, flush_valid, flush_int);
      g = pick(1'b1, flush_valid, flush_int);
      chk("alloc_full (R8)", int'(alloc_full), int'(model_full()));
      chk("alloc_seq (R9)", int'(alloc_seq), nxt % (1 << SEQ_W));
      chk("alu_iss_valid", int'(alu_iss_valid), int'(a >= 0 && alu_free));
      if (a >= 0 && alu_free) begin
        chk("alu_iss_seq", int'(alu_iss_seq), q[a].seq % (1 << SEQ_W));
        chk("alu_iss_dst", int'(alu_iss_dst), q[a].dst);
        chk("alu_iss_src1", int'(alu_iss_src1), q[a].s1);
        chk("alu_iss_src2", int'(alu_iss_src2), q[a].s2);
      end
      chk("agu_iss_valid", int'(agu_iss_valid), int'(g >= 0 && agu_free));
      if (g >= 0 && agu_free) begin
        chk("agu_iss_seq", int'(agu_iss_seq), q[g].seq % (1 << SEQ_W));
        chk("agu_iss_dst", int'(agu_iss_dst), q[g].dst);
        chk("agu_iss_src1", int'(agu_iss_src1), q[g].s1);
        chk("agu_iss_src2", int'(agu_iss_src2), q[g].s2);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      nxt = 0;
      ldq_v = 0;
      ldq_t = 0;
    end else begin
      int a, g;
      bit full_now;
      ent_t e;
      full_now = model_full();
      a = pick(1'b0, flush_valid, flush_int);
      g = pick(1'b1, flush_valid, flush_int);
      if (!alu_free) a = -1;
      if (!agu_free) g = -1;
      if (a > g) begin
        q.delete(a);
        if (g >= 0) q.delete(g);
      end else begin
        if (g >= 0) q.delete(g);
        if (a >= 0) q.delete(a);
      end
      if (flush_valid)
        for (int k = q.size() - 1; k >= 0; k--)
          if (q[k].seq > flush_int) q.delete(k);
      foreach (q[k]) begin
        if (hit(q[k].s1)) q[k].r1 = 1;
        if (hit(q[k].s2)) q[k].r2 = 1;
      end
      if (alloc_valid && !full_now && !flush_valid) begin
        e.seq = nxt; e.cls = alloc_cls;
        e.s1 = int'(alloc_src1); e.s2 = int'(alloc_src2); e.dst = int'(alloc_dst);
        e.r1 = alloc_src1_rdy || hit(int'(alloc_src1));
        e.r2 = alloc_src2_rdy || hit(int'(alloc_src2));
        q.push_back(e);
        nxt++;
      end
      ldq_v = ld_cmp_valid;
      ldq_t = int'(ld_cmp_tag);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    alloc_valid = 0;
    flush_valid = 0;
    cmp_valid = 0;
    ld_cmp_valid = 0;
  endtask

  task automatic put(bit c, int s1, bit r1, int s2, bit r2, int d);
    alloc_valid = 1; alloc_cls = c;
    alloc_src1 = TAG_W'(s1); alloc_src1_rdy = r1;
    alloc_src2 = TAG_W'(s2); alloc_src2_rdy = r2;
    alloc_dst = TAG_W'(d);
  endtask

  task automatic wake(int t);
    cmp_valid = 1; cmp_tag = TAG_W'(t);
  endtask

  task automatic do_flush(int s);
    flush_valid = 1; flush_int = s; flush_seq = SEQ_W'(s);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    req = "R1";
    idle(2);

    req = "R2";
    put(0, 5, 0, 1, 1, 20); tick();
    put(1, 2, 1, 3, 1, 21); tick();
    idle(2);
    req = "R5";
    wake(5); tick();
    idle(2);

    req = "R4";
    alu_free = 0;
    put(0, 1, 1, 1, 1, 30); tick();
    put(0, 1, 1, 1, 1, 31); tick();
    put(0, 1, 1, 1, 1, 32); tick();
    idle(2);
    req = "R3";
    alu_free = 1;
    idle(4);

    req = "R6";
    put(1, 9, 0, 1, 1, 33); tick();
    ld_cmp_valid = 1; ld_cmp_tag = 9; tick();
    idle(3);

    req = "R5";
    put(0, 11, 0, 12, 1, 34); wake(11); tick();
    idle(2);

    req = "R7";
    begin
      int base;
      base = nxt;
      for (int k = 0; k < 5; k++) begin put(k % 2, 40, 0, 1, 1, 50 + k); tick(); end
      do_flush(base + 1); put(0, 1, 1, 1, 1, 59); tick();
      idle(1);
      wake(40); tick();
      idle(3);
    end

    req = "R8";
    for (int k = 0; k < 20; k++) begin put(k % 2, 41, 0, 42, 0, k); tick(); end
    idle(2);
    wake(41); tick();
    wake(42); tick();
    idle(12);

    req = "R9";
    put(1, 60, 0, 1, 1, 61); tick();
    for (int k = 0; k < 75; k++) begin put(0, 1, 1, 2, 1, k % 32); tick(); end
    wake(60); tick();
    idle(3);

    req = "R3";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 9) < 6)
        put($urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 1),
            $urandom_range(0, 15), $urandom_range(0, 1), $urandom_range(0, 63));
      if ($urandom_range(0, 9) < 4) wake($urandom_range(0, 15));
      if ($urandom_range(0, 9) < 2) begin
        ld_cmp_valid = 1; ld_cmp_tag = TAG_W'($urandom_range(0, 15));
      end
      if (q.size() > 0 && $urandom_range(0, 99) < 3)
        do_flush(q[$urandom_range(0, q.size() - 1)].seq);
      alu_free = ($urandom_range(0, 9) < 7);
      agu_free = ($urandom_range(0, 9) < 7);
      tick();
    end
    alu_free = 1; agu_free = 1;
    for (int t = 0; t < 16; t++) begin wake(t); tick(); end
    idle(20);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule